// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running time value for precision time protocol timestamping. It holds a 40-bit nanosecond count and a 32-bit fraction accumulator below it. On every enabled clock cycle the count moves forward by a fixed 8 ns. A signed fractional correction is also added to the accumulator on each such cycle. Software uses that correction to trim the effective frequency. When the fraction overflows, one extra nanosecond is added. When it underflows, one nanosecond is taken away.

Software reaches the block through a plain 32-bit register port with one-cycle write and read strobes. Read data arrives one cycle after the strobe, marked by a valid pulse, and the port has no back-pressure. The time is seen as three words: sub-nanosecond, low nanoseconds and high nanoseconds. Software reads them in that order. The read of the sub-nanosecond word freezes the whole value, so the two later reads stay coherent. To set the time, software writes the low word first, which is held in a staging register. It then writes the high word, which loads both at once. A halt bit stops the counter.

Register offsets on `reg_addr`: 0 sub-nanosecond word, 1 low word, 2 high word, 3 increment adjust, 4 auxiliary control.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count, the fraction and the increment-adjust register are zero, and the counter is running. Reads of offsets 3 and 4 return 0.
- R2: When the increment adjust is zero, every enabled cycle adds exactly 8 to the nanosecond count, and the fraction stays unchanged.
- R3: In the increment-adjust word (offset 3), bit 31 = 0 means add. Bits 30:0 are added to the fraction each enabled cycle, and a carry out of the 32-bit fraction adds 1 ns on top of the 8 ns step. The register reads back as written.
- R4: When bit 31 of the increment adjust is 1, bits 30:0 are subtracted from the fraction instead. A borrow removes 1 ns from that cycle's 8 ns step.
- R5: The 40-bit count wraps silently modulo 2^40.
- R6: A read of the high word (offset 2) returns count bits 39:32 in bits 7:0, and bits 31:8 read as zero. Written values of bits 31:8 are dropped.
- R7: A read of the sub-nanosecond word (offset 0) returns the live fraction and captures the live count. Later reads of the low word (offset 1) and the high word return that captured count, even while the counter runs on.
- R8: A write to the low word only stages the value, and the count keeps its old value. A write to the high word then loads {high[7:0], staged low} into the count and clears the fraction.
- R9: Bit 31 of the auxiliary control word (offset 4) set to 1 halts the counter, and the count and fraction then hold. Writing 0 resumes counting. The write takes effect on the clock edge that samples it, so the first counting edge is the one after that.
- R10: A read strobe produces exactly one `reg_rd_valid` pulse, one cycle later, with the data.
- R11: Writes to the sub-nanosecond word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_rd_en | input | 1 | Single-cycle read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |

## Verification
The counter is exercised with a zero correction, a positive quarter-nanosecond correction and a negative one, each over a counted number of enabled cycles. A zero correction shows the bare 8 ns step. The positive case gives carries that add nanoseconds, and the negative case gives borrows that remove them, including a borrow on the very first cycle. A load just below 2^40 separates a silent wrap from saturation. Free-running snapshot reads, taken several cycles apart, tell a captured value from a live one. Staged-only low writes and halted idle periods show that the count does not move when it should not.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    TC_SUBNS  = 3'd0,
    TC_NS_LO  = 3'd1,
    TC_NS_HI  = 3'd2,
    TC_INCADJ = 3'd3,
    TC_AUXCTL = 3'd4
  } tc_addr_e;
endpackage

// File: rtl/tc_regs.sv
// Increment register, halt bit and low-word staging.
module tc_regs #(
  parameter int NS_W   = 40,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              inc_neg,
  output logic [DATA_W-2:0] inc_mag,
  output logic [DATA_W-1:0] inc_word,
  output logic              halt,
  output logic              load,
  output logic [NS_W-1:0]   load_ns
);
  import tc_pkg::*;
  localparam int HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] inc_q, lo_stage_q;
  logic              halt_q;
  tc_addr_e          a;

  assign a = tc_addr_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q      <= '0;
      lo_stage_q <= '0;
      halt_q     <= 1'b0;
    end else if (wr_en) begin
      case (a)
        TC_INCADJ: inc_q      <= wr_data;
        TC_AUXCTL: halt_q     <= wr_data[DATA_W-1];
        TC_NS_LO:  lo_stage_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign inc_word = inc_q;
  assign inc_neg  = inc_q[DATA_W-1];
  assign inc_mag  = inc_q[DATA_W-2:0];
  assign halt     = halt_q;
  assign load     = wr_en && (a == TC_NS_HI);
  assign load_ns  = {wr_data[HI_W-1:0], lo_stage_q};

  assert_halt_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a == TC_AUXCTL) |=> (halt == $past(wr_data[DATA_W-1])));
endmodule

// File: rtl/tc_accum.sv
// Fraction accumulator and nanosecond count.
module tc_accum #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              inc_neg,
  input  logic [FRAC_W-2:0] inc_mag,
  input  logic              load,
  input  logic [NS_W-1:0]   load_ns,
  output logic [FRAC_W-1:0] frac_q,
  output logic [NS_W-1:0]   ns_q
);
  localparam logic [NS_W-1:0] STEP = NS_W'(STEP_NS);

  logic [FRAC_W:0]   sum_ext, dif_ext;
  logic [FRAC_W-1:0] frac_nx;
  logic [NS_W-1:0]   ns_nx;

  always_comb begin
    sum_ext = {1'b0, frac_q} + {2'b00, inc_mag};
    dif_ext = {1'b0, frac_q} - {2'b00, inc_mag};
    if (inc_neg) begin
      frac_nx = dif_ext[FRAC_W-1:0];
      ns_nx   = ns_q + STEP - NS_W'(dif_ext[FRAC_W]);
    end else begin
      frac_nx = sum_ext[FRAC_W-1:0];
      ns_nx   = ns_q + STEP + NS_W'(sum_ext[FRAC_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      ns_q   <= '0;
    end else if (load) begin
      frac_q <= '0;
      ns_q   <= load_ns;
    end else if (run) begin
      frac_q <= frac_nx;
      ns_q   <= ns_nx;
    end
  end

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> (ns_q == $past(ns_q) && frac_q == $past(frac_q)));
  assert_load_clears_frac_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (frac_q == '0 && ns_q == $past(load_ns)));
  assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !inc_neg) |=>
      (ns_q == $past(ns_q) + STEP || ns_q == $past(ns_q) + STEP + NS_W'(1)));
  assert_neg_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && inc_neg) |=>
      (ns_q == $past(ns_q) + STEP || ns_q == $past(ns_q) + STEP - NS_W'(1)));
endmodule

// File: rtl/tc_snapshot.sv
// Snapshot capture and read-data path.
module tc_snapshot #(
  parameter int NS_W   = 40,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  input  logic [DATA_W-1:0] frac_live,
  input  logic [NS_W-1:0]   ns_live,
  input  logic [DATA_W-1:0] inc_word,
  input  logic              halt,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import tc_pkg::*;
  localparam int HI_W = NS_W - DATA_W;

  logic [NS_W-1:0] snap_ns;
  tc_addr_e        a;

  assign a = tc_addr_e'(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_ns  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (a)
          TC_SUBNS: begin
            snap_ns <= ns_live;
            rd_data <= frac_live;
          end
          TC_NS_LO:  rd_data <= snap_ns[DATA_W-1:0];
          TC_NS_HI:  rd_data <= {{(DATA_W-HI_W){1'b0}}, snap_ns[NS_W-1:DATA_W]};
          TC_INCADJ: rd_data <= inc_word;
          TC_AUXCTL: rd_data <= {halt, {(DATA_W-1){1'b0}}};
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  assert_one_valid_per_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(rd_en)));
  assert_hi_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == TC_NS_HI) |=> (rd_data[DATA_W-1:HI_W] == '0));
  assert_snap_only_on_subns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && a == TC_SUBNS) |=> $stable(snap_ns));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int NS_W    = 40,
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd_valid
);
  logic              inc_neg, halt, load;
  logic [DATA_W-2:0] inc_mag;
  logic [DATA_W-1:0] inc_word, frac_q;
  logic [NS_W-1:0]   load_ns, ns_q;

  tc_regs #(.NS_W(NS_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .inc_neg(inc_neg), .inc_mag(inc_mag),
    .inc_word(inc_word), .halt(halt), .load(load), .load_ns(load_ns)
  );

  tc_accum #(.NS_W(NS_W), .FRAC_W(DATA_W), .STEP_NS(STEP_NS)) u_accum (
    .clk(clk), .rst_n(rst_n), .run(!halt), .inc_neg(inc_neg),
    .inc_mag(inc_mag), .load(load), .load_ns(load_ns),
    .frac_q(frac_q), .ns_q(ns_q)
  );

  tc_snapshot #(.NS_W(NS_W), .DATA_W(DATA_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_en), .rd_addr(reg_addr),
    .frac_live(frac_q), .ns_live(ns_q), .inc_word(inc_word), .halt(halt),
    .rd_data(reg_rdata), .rd_valid(reg_rd_valid)
  );
endmodule

// File: tb/ns_time_counter_tb.sv
`timescale 1ns/1ps
module ns_time_counter_tb;
  localparam logic [2:0] A_SUB = 3'd0, A_LO = 3'd1, A_HI = 3'd2, A_INC = 3'd3, A_AUX = 3'd4;
  localparam logic [31:0] HALT = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rd_valid;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ns_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rd_valid(reg_rd_valid)
  );

  // Monitor: pops the scoreboard on every valid read.
  always @(negedge clk) begin
    if (rst_n && reg_rd_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected read valid, data %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  // Exactly m enabled edges, then halted again.
  task automatic run_for(input int m);
    wr(A_AUX, 32'h0);
    for (int i = 0; i < m - 1; i++) @(negedge clk);
    wr(A_AUX, HALT);
  endtask

  task automatic load_time(input logic [31:0] lo, input logic [31:0] hi);
    wr(A_LO, lo);
    wr(A_HI, hi);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_INC, 32'h0, "R1");
    rd(A_AUX, 32'h0, "R1");

    // R9 halt; R8 load; R6 high word
    wr(A_AUX, HALT);
    rd(A_AUX, HALT, "R9");
    load_time(32'h1000_0000, 32'h0000_0022);
    rd(A_SUB, 32'h0, "R8");
    rd(A_LO, 32'h1000_0000, "R8");
    rd(A_HI, 32'h22, "R6");

    // R11 sub-ns write ignored
    wr(A_SUB, 32'h1234_5678);
    rd(A_SUB, 32'h0, "R11");

    // R9 halted count holds
    repeat (20) @(negedge clk);
    rd(A_SUB, 32'h0, "R9");
    rd(A_LO, 32'h1000_0000, "R9");

    // R8 staged low write alone has no effect
    wr(A_LO, 32'h5555_0000);
    rd(A_SUB, 32'h0, "R8");
    rd(A_LO, 32'h1000_0000, "R8");
    wr(A_HI, 32'hABCD_EF05);
    rd(A_SUB, 32'h0, "R8");
    rd(A_LO, 32'h5555_0000, "R8");
    rd(A_HI, 32'h05, "R6");

    // R2 plain 8 ns step, 50 cycles
    run_for(50);
    rd(A_SUB, 32'h0, "R2");
    rd(A_LO, 32'h5555_0190, "R2");
    rd(A_HI, 32'h05, "R2");

    // R3 positive correction of 0.25 ns over 10 cycles
    load_time(32'h0, 32'h0);
    wr(A_INC, 32'h4000_0000);
    rd(A_INC, 32'h4000_0000, "R3");
    run_for(10);
    rd(A_SUB, 32'h8000_0000, "R3");
    rd(A_LO, 32'd82, "R3");

    // R4 negative correction: borrow on first cycle, then 10 total
    load_time(32'h0, 32'h0);
    wr(A_INC, 32'hC000_0000);
    run_for(1);
    rd(A_SUB, 32'hC000_0000, "R4");
    rd(A_LO, 32'd7, "R4");
    run_for(9);
    rd(A_SUB, 32'h8000_0000, "R4");
    rd(A_LO, 32'd77, "R4");

    // R8 high-word write clears the fraction
    load_time(32'h0000_0100, 32'h0);
    rd(A_SUB, 32'h0, "R8");
    rd(A_LO, 32'h0000_0100, "R8");

    // R5 wrap modulo 2^40
    wr(A_INC, 32'h0);
    load_time(32'hFFFF_FFF8, 32'h0000_00FF);
    run_for(3);
    rd(A_SUB, 32'h0, "R5");
    rd(A_LO, 32'h10, "R5");
    rd(A_HI, 32'h0, "R5");

    // R7 snapshot while free running
    load_time(32'h0, 32'h0);
    wr(A_AUX, 32'h0);
    rd(A_SUB, 32'h0, "R7");
    repeat (5) @(negedge clk);
    rd(A_LO, 32'h0, "R7");
    rd(A_HI, 32'h0, "R7");
    rd(A_LO, 32'h0, "R7");
    rd(A_SUB, 32'h0, "R7");
    rd(A_LO, 32'd72, "R7");
    wr(A_AUX, HALT);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R10: %0d reads without valid, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule